// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM. The RAM has a 19-bit address, 8 data bits, and active-low chip select, write strobe and output enable. The requester sends one read or write at a time over a valid/ready port. The controller turns each request into a pin-level cycle: address setup, strobe pulse, data capture or drive, and recovery. Read results come back as a byte with a single-cycle valid pulse.

All timing comes from four cycle-count parameters, which the integrator sets from the RAM speed grade and the controller clock period:

- `ADDR_SETUP_CYC`: address setup.
- `RD_WAIT_CYC`: read access time.
- `WR_PULSE_CYC`: write data drive time.
- `TURN_CYC`: bus turnaround.

The write strobe runs with output enable held high, so the shorter write-pulse rating applies. The controller drives the data bus only after the RAM has had the turnaround time to release its outputs. Between accesses the controller always deselects the chip, so every write gets its own rising strobe edge.

The default counts suit a 10 ns RAM with a 100 MHz controller clock.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and until the first request, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, `dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for ADDR_SETUP_CYC+RD_WAIT_CYC+TURN_CYC cycles for a read (`req_we`=0), or ADDR_SETUP_CYC+2*TURN_CYC+WR_PULSE_CYC cycles for a write (`req_we`=1).
- R3: A read returns the byte stored at `req_addr` on `rsp_rdata`, together with a `rsp_valid` pulse exactly one cycle long. Each read gives exactly one such pulse, and a write gives none.
- R4: During a read, `sram_ce_n` is low for ADDR_SETUP_CYC+RD_WAIT_CYC cycles and `sram_oe_n` is low for RD_WAIT_CYC cycles. Whenever `sram_oe_n` is low, `sram_we_n` is high and `sram_ce_n` is low.
- R5: A write stores `req_wdata` at `req_addr` on a single rising edge of `sram_we_n`. `sram_oe_n` stays high for the whole write.
- R6: During a write, `sram_we_n` is low for TURN_CYC+WR_PULSE_CYC cycles. `dq_oe` is high only while `sram_we_n` and `sram_ce_n` are both low, is first raised only after `sram_we_n` has been low for TURN_CYC cycles, and stays high for WR_PULSE_CYC cycles up to the strobe's rising edge.
- R7: `dq_oe` is never high in a cycle where `sram_oe_n` is low.
- R8: `sram_addr` does not change in any cycle where `sram_ce_n` stays low from the previous cycle.
- R9: Whenever `req_ready` is high, `sram_ce_n` is high and `dq_oe` is low. Every access ends with at least TURN_CYC cycles with `sram_ce_n` high.
- R10: `req_valid`, `req_we`, `req_addr` and `req_wdata` have no effect while `req_ready` is low: no extra strobe, and no change to the access in progress or to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 19 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| dq_o | output | 8 | Data driven toward the RAM |
| dq_oe | output | 1 | Enable for the data bus drivers |
| dq_i | input | 8 | Data sampled from the RAM |

## Verification
A sequencer in the wrong state shows up at the pins in the same cycle, because every pin comes straight from a register loaded from the next-state decode. The symptoms include:

- a strobe pulse of the wrong length;
- drive overlapping output enable;
- the chip selected while the controller reports ready.

A wait counter that is off by one changes the pulse lengths and the busy time counted over one access. A wrong capture cycle returns a byte that does not match the reference model on the very next `rsp_valid`. A missed or duplicated strobe edge corrupts memory, which shows up only at a later read of that address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_WAIT  = 3'd2,
    ST_WR_TURN  = 3'd3,
    ST_WR_DRIVE = 3'd4,
    ST_RECOVER  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Pin levels that belong to each sequencer state
  function automatic pin_ctl_t pins_for(seq_state_e st);
    pin_ctl_t p;
    p = PINS_IDLE;
    case (st)
      ST_SETUP:    p.ce_n = 1'b0;
      ST_RD_WAIT:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WR_TURN:  begin p.ce_n = 1'b0; p.we_n = 1'b0; end
      ST_WR_DRIVE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      default:     p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_SETUP_CYC = 1,
  parameter int RD_WAIT_CYC    = 2,
  parameter int WR_PULSE_CYC   = 1,
  parameter int TURN_CYC       = 1,
  parameter int CNT_W          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       is_write,
  output logic       accept,
  output logic       capture,
  output logic       idle,
  output seq_state_e state_nxt
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(ADDR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_d = ST_SETUP;
      ST_SETUP:    if (tmr_done)  state_d = is_write ? ST_WR_TURN : ST_RD_WAIT;
      ST_RD_WAIT:  if (tmr_done)  state_d = ST_RECOVER;
      ST_WR_TURN:  if (tmr_done)  state_d = ST_WR_DRIVE;
      ST_WR_DRIVE: if (tmr_done)  state_d = ST_RECOVER;
      ST_RECOVER:  if (tmr_done)  state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  // Timer reloads on each state entry with that state's dwell minus one
  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_SETUP:    tmr_val = SETUP_LD;
      ST_RD_WAIT:  tmr_val = RD_LD;
      ST_WR_TURN:  tmr_val = TURN_LD;
      ST_WR_DRIVE: tmr_val = WR_LD;
      ST_RECOVER:  tmr_val = TURN_LD;
      default:     tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_valid;
  assign capture   = (state_q == ST_RD_WAIT) && tmr_done;
  assign state_nxt = state_d;

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_nxt,
  output logic       ce_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  pin_ctl_t pin_q, pin_d;

  always_comb begin
    pin_d = pins_for(state_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= PINS_IDLE;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign ce_n  = pin_q.ce_n;
  assign we_n  = pin_q.we_n;
  assign oe_n  = pin_q.oe_n;
  assign dq_oe = pin_q.dq_oe;

endmodule

// File: rtl/sram_data_regs.sv
module sram_data_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  // Request latch: loads only when the sequencer takes a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= in_we;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
    end
  end

  assign is_write = we_q;
  assign addr     = addr_q;
  assign wdata    = wdata_q;
  assign rvalid   = rvalid_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 8,
  parameter int ADDR_SETUP_CYC = 1,
  parameter int RD_WAIT_CYC    = 2,
  parameter int WR_PULSE_CYC   = 1,
  parameter int TURN_CYC       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);

  localparam int MAX_A   = (ADDR_SETUP_CYC > RD_WAIT_CYC) ? ADDR_SETUP_CYC : RD_WAIT_CYC;
  localparam int MAX_B   = (WR_PULSE_CYC > TURN_CYC) ? WR_PULSE_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // Reset asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic       accept, capture, idle, is_write;
  seq_state_e state_nxt;

  sram_seq_fsm #(
    .ADDR_SETUP_CYC (ADDR_SETUP_CYC),
    .RD_WAIT_CYC    (RD_WAIT_CYC),
    .WR_PULSE_CYC   (WR_PULSE_CYC),
    .TURN_CYC       (TURN_CYC),
    .CNT_W          (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .is_write  (is_write),
    .accept    (accept),
    .capture   (capture),
    .idle      (idle),
    .state_nxt (state_nxt)
  );

  sram_pin_regs u_pins (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .state_nxt (state_nxt),
    .ce_n      (sram_ce_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (dq_oe)
  );

  sram_data_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .accept   (accept),
    .capture  (capture),
    .in_we    (req_we),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .dq_i     (dq_i),
    .is_write (is_write),
    .addr     (sram_addr),
    .wdata    (dq_o),
    .rvalid   (rsp_valid),
    .rdata    (rsp_rdata)
  );

  assign req_ready = idle;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              dq_oe
);

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !sram_oe_n)); // R7

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n)); // R5

  AST_READ_CONTROLS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n)); // R4

  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!sram_we_n && !sram_ce_n)); // R6

  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!sram_we_n)); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R8

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !dq_oe)); // R9

  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

endmodule

bind sram_port_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .dq_oe     (dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int SETUP = 1, RDW = 2, WRP = 1, TURN = 1;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr, sram_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, dq_o, dq_i;
  logic          rsp_valid, sram_ce_n, sram_we_n, sram_oe_n, dq_oe;

  int checks = 0, fails = 0;
  bit finished = 0;

  sram_port_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ADDR_SETUP_CYC(SETUP),
    .RD_WAIT_CYC(RDW), .WR_PULSE_CYC(WRP), .TURN_CYC(TURN)
  ) i_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // RAM model and reference memory
  logic [DW-1:0] ram [int unsigned];
  logic [DW-1:0] ref_mem [int unsigned];

  function automatic logic [DW-1:0] ram_rd(input logic [AW-1:0] a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic int exp_busy(input bit wr);
    return wr ? (SETUP + 2*TURN + WRP) : (SETUP + RDW + TURN);
  endfunction

  always @(*) begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n) dq_i = ram_rd(sram_addr);
    else                                       dq_i = 8'hA5;
  end

  // Cumulative monitor counters, sampled on falling edges
  int m_busy, m_ce_low, m_oe_low, m_we_low, m_drive, m_rvalid;
  int m_conflict, m_oe_in_wr, m_addr_move, m_we_edges, m_bad_edge;
  logic [DW-1:0] last_rdata;
  logic          p_ce_n, p_we_n, p_dq_oe, p_ok;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dq_o;

  initial begin
    m_busy = 0; m_ce_low = 0; m_oe_low = 0; m_we_low = 0; m_drive = 0; m_rvalid = 0;
    m_conflict = 0; m_oe_in_wr = 0; m_addr_move = 0; m_we_edges = 0; m_bad_edge = 0;
    p_ok = 0; p_ce_n = 1; p_we_n = 1; p_dq_oe = 0; p_addr = '0; p_dq_o = '0;
    last_rdata = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) m_busy++;
      if (!sram_ce_n) m_ce_low++;
      if (!sram_oe_n) m_oe_low++;
      if (!sram_we_n) m_we_low++;
      if (dq_oe) m_drive++;
      if (rsp_valid) begin m_rvalid++; last_rdata = rsp_rdata; end
      if (dq_oe && !sram_oe_n) m_conflict++;
      if (!sram_we_n && !sram_oe_n) m_oe_in_wr++;
      if (p_ok && !p_ce_n && !sram_ce_n && (p_addr != sram_addr)) m_addr_move++;
      if (p_ok && !p_we_n && !p_ce_n && sram_we_n) begin
        m_we_edges++;
        ram[p_addr] = p_dq_o;
        if (!p_dq_oe) m_bad_edge++;
      end
      p_ok = 1; p_ce_n = sram_ce_n; p_we_n = sram_we_n;
      p_dq_oe = dq_oe; p_addr = sram_addr; p_dq_o = dq_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One access; junk drives the request port while busy (R10)
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit junk);
    int b0, ce0, oe0, we0, dr0, rv0, cf0, ow0, am0, ed0, be0;
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    b0 = m_busy; ce0 = m_ce_low; oe0 = m_oe_low; we0 = m_we_low; dr0 = m_drive;
    rv0 = m_rvalid; cf0 = m_conflict; ow0 = m_oe_in_wr; am0 = m_addr_move;
    ed0 = m_we_edges; be0 = m_bad_edge;
    cyc = 0;
    do begin
      @(negedge clk); #1;
      cyc++;
      if (junk && cyc == 1) begin
        req_valid = 1; req_we = 1; req_addr = a ^ 19'h40000; req_wdata = ~d;
      end else begin
        req_valid = 0; req_we = $urandom(); req_addr = $urandom(); req_wdata = $urandom();
      end
    end while (!req_ready && cyc < 50);
    req_valid = 0;
    if (wr) ref_mem[a] = d;
    check("R2 busy cycles", m_busy - b0, exp_busy(wr));
    check("R9 deselected when ready", int'(sram_ce_n && !dq_oe), 1);
    check("R7 drive vs output enable", m_conflict - cf0, 0);
    check("R8 address moved while selected", m_addr_move - am0, 0);
    if (wr) begin
      check("R5 write strobe edges", m_we_edges - ed0, 1);
      check("R5 output enable low in write", m_oe_in_wr - ow0, 0);
      check("R6 strobe low cycles", m_we_low - we0, TURN + WRP);
      check("R6 drive cycles", m_drive - dr0, WRP);
      check("R6 data driven at strobe edge", m_bad_edge - be0, 0);
      check("R3 no response on write", m_rvalid - rv0, 0);
      check("R9 select low cycles (write)", m_ce_low - ce0, SETUP + TURN + WRP);
    end else begin
      check("R3 one response per read", m_rvalid - rv0, 1);
      check("R3 read data", int'(last_rdata), int'(ref_rd(a)));
      check("R4 output enable cycles", m_oe_low - oe0, RDW);
      check("R4 select low cycles", m_ce_low - ce0, SETUP + RDW);
      check("R4 no drive in read", m_drive - dr0, 0);
      check("R10 no strobe in read", m_we_edges - ed0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [16];
    void'($urandom(32'd1234));
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 ce_n in reset", int'(sram_ce_n), 1);
    check("R1 dq_oe in reset", int'(dq_oe), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 we_n after reset", int'(sram_we_n), 1);
    check("R1 oe_n after reset", int'(sram_oe_n), 1);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);

    // Directed corners: edge addresses, back-to-back writes, overwrite
    access(1, 19'h00000, 8'h3C, 0);
    access(1, 19'h7FFFF, 8'hC3, 0);
    access(0, 19'h00000, 8'h00, 0);
    access(0, 19'h7FFFF, 8'h00, 0);
    access(1, 19'h00000, 8'hFF, 0);
    access(1, 19'h00000, 8'h00, 0);
    access(0, 19'h00000, 8'h00, 0);
    access(0, 19'h12345, 8'h00, 0);
    // R10: junk request while busy must not disturb memory
    access(1, 19'h00100, 8'h5A, 1);
    access(0, 19'h40100, 8'h00, 1);
    access(0, 19'h00100, 8'h00, 0);

    // Random mix over a small address pool
    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom());
    for (int i = 0; i < 80; i++) begin
      access(bit'($urandom() & 1), pool[$urandom() % 16], DW'($urandom()),
             bit'(($urandom() % 4) == 0));
    end
    for (int i = 0; i < 16; i++) access(0, pool[i], 8'h00, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule